// File: doc/BRIEF.md
# CAN node mode status shadow

This block sits beside a CAN controller on the host side. It works out whether the node is in sleep mode or in loopback mode from signals the host can trust, because the controller's own mode status bits can read wrong. The block keeps a count of transmit messages that are still outstanding. It watches the controller's bus-idle and bus-busy flags. It also times a fixed settle delay in CAN bit-clock ticks after loopback is requested. The outputs are a registered sleep indication, a one-cycle wake event, a wake-pending flag and a loopback indication.

There are two state machines. The sleep machine has the states AWAKE and ASLEEP:
- AWAKE goes to ASLEEP on an *entry* transition: bus idle, no outstanding messages, and no message written in the same cycle.
- ASLEEP goes to AWAKE on a *wake* transition when the bus-busy flag reads 1.
- A message write while ASLEEP does not change state. It only sets the wake-pending flag.

The loopback machine has the states CONFIG, NORMAL, SETTLE and LOOP:
- CONFIG goes to SETTLE on a *loop request*, which is a control write with both loopback-request and core-enable at 1.
- CONFIG goes to NORMAL on an *enable*, which is a control write with core-enable 1 and loopback-request 0.
- SETTLE goes to LOOP on the *settle done* transition, at the sixth CAN tick.
- Any state returns to CONFIG on a *disable*, which is a control write with core-enable 0.
- Any other control write leaves NORMAL, SETTLE and LOOP unchanged.

Top module: `can_mode_shadow`

## Requirements
- R1: The outstanding count goes up by one on each `tx_write` and down by one on each `tx_done`. It saturates at 0 and at `NUM_BUF` (default 4). A cycle with both strobes leaves it unchanged. The count is observed through sleep entry, which needs the count to be 0.
- R2: In AWAKE, a cycle with `bus_idle`=1, a count of 0 and `tx_write`=0 makes `sleep_o` 1 from the next cycle on.
- R3: `sleep_o` stays 0 in three cases: messages are outstanding, `bus_idle` is 0, or `tx_write` is 1 in the idle cycle. This holds whatever the value of `bus_busy`.
- R4: A `tx_write` while `sleep_o` is 1 (without `bus_busy`) sets `wake_pend_o` to 1 in the next cycle. `sleep_o` stays 1.
- R5: While `sleep_o` is 1, `bus_busy`=1 makes `sleep_o` 0 in the next cycle. In that same next cycle `wake_pulse_o` is 1, and it lasts exactly one cycle.
- R6: `wake_pend_o` returns to 0 in the cycle where `wake_pulse_o` fires.
- R7: From CONFIG, a control write with `loop_req`=1 and `core_en`=1 makes `loop_o` 1 in the cycle after the sixth following `can_tick`, and not before. Ticks in the cycle of the write itself do not count.
- R8: After an enable write (`core_en`=1, `loop_req`=0), a later loop request is ignored: `loop_o` stays 0 however many ticks follow.
- R9: A control write with `core_en`=0 makes `loop_o` 0 in the next cycle and restarts the settle delay. A new request then needs six fresh ticks.
- R10: Under synchronous reset every output is 0, the count is 0 and the loopback machine is in CONFIG.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_write | input | 1 | Strobe: host wrote a message into a transmit buffer |
| tx_done | input | 1 | Strobe: a transmit completed |
| bus_idle | input | 1 | Controller bus-idle flag |
| bus_busy | input | 1 | Controller bus-busy flag |
| ctrl_write | input | 1 | Strobe: loopback-request and core-enable bits written |
| loop_req | input | 1 | Value written to the loopback-request bit |
| core_en | input | 1 | Value written to the core-enable bit |
| can_tick | input | 1 | One-cycle CAN bit-clock enable |
| sleep_o | output | 1 | Node inferred to be asleep |
| wake_pulse_o | output | 1 | One-cycle wake event |
| wake_pend_o | output | 1 | Wake-up is imminent after a write while asleep |
| loop_o | output | 1 | Node inferred to be in loopback |

## Verification
The hardest behaviour to reach from the ports is the outstanding count: saturation at both ends, and the hold when both strobes arrive together. The count has no output of its own. The stimulus holds `bus_idle` at 0 while it builds the count up or down. For the top end it writes five messages and then completes four. For the bottom end it completes messages on an empty count and then writes one. For the hold it issues a write and a completion in the same cycle. Only then does it raise `bus_idle` for one cycle, so whether sleep entry happens shows the exact count.

// File: rtl/can_shadow_pkg.sv
package can_shadow_pkg;
    typedef enum logic {
        S_AWAKE,
        S_ASLEEP
    } sleep_state_t;

    typedef enum logic [1:0] {
        L_CONFIG,
        L_NORMAL,
        L_SETTLE,
        L_LOOP
    } loop_state_t;
endpackage

// File: rtl/tx_occupancy.sv
module tx_occupancy #(
    parameter int NUM_BUF = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic tx_write,
    input  logic tx_done,
    output logic empty
);
    localparam int CW = $clog2(NUM_BUF + 1);
    localparam logic [CW-1:0] FULL = CW'(NUM_BUF);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (tx_write && !tx_done && cnt < FULL) begin
            cnt <= cnt + CW'(1);
        end else if (tx_done && !tx_write && cnt != '0) begin
            cnt <= cnt - CW'(1);
        end
    end

    assign empty = (cnt == '0);

    // R1: the count never exceeds the configured number of buffers
    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (rst)
        cnt <= FULL);

    // R1: both strobes together hold the count
    p_cnt_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (tx_write && tx_done) |=> $stable(cnt));

    // R1: a completion on an empty count keeps it at zero
    p_cnt_floor_r1: assert property (@(posedge clk) disable iff (rst)
        (empty && tx_done && !tx_write) |=> empty);
endmodule

// File: rtl/sleep_tracker.sv
module sleep_tracker
    import can_shadow_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tx_write,
    input  logic buf_empty,
    input  logic bus_idle,
    input  logic bus_busy,
    output logic sleep_o,
    output logic wake_pulse_o,
    output logic wake_pend_o
);
    sleep_state_t state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            S_AWAKE:  if (bus_idle && buf_empty && !tx_write) state_nx = S_ASLEEP;
            S_ASLEEP: if (bus_busy) state_nx = S_AWAKE;
            default:  state_nx = S_AWAKE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= S_AWAKE;
        else     state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wake_pulse_o <= 1'b0;
            wake_pend_o  <= 1'b0;
        end else begin
            wake_pulse_o <= 1'b0;
            unique case (state)
                S_AWAKE: begin
                    if (state_nx == S_ASLEEP) wake_pend_o <= 1'b0;
                end
                S_ASLEEP: begin
                    if (bus_busy) begin
                        wake_pulse_o <= 1'b1;
                        wake_pend_o  <= 1'b0;
                    end else if (tx_write) begin
                        wake_pend_o  <= 1'b1;
                    end
                end
                default: wake_pend_o <= 1'b0;
            endcase
        end
    end

    assign sleep_o = (state == S_ASLEEP);

    // R2: sleep entry only after an idle cycle with no outstanding messages
    p_entry_gate_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(sleep_o) |-> $past(bus_idle && buf_empty && !tx_write));

    // R4: a write while asleep raises the pending flag
    p_pend_set_r4: assert property (@(posedge clk) disable iff (rst)
        (sleep_o && tx_write && !bus_busy) |=> (wake_pend_o && sleep_o));

    // R5: busy while asleep wakes the node with a pulse
    p_wake_on_busy_r5: assert property (@(posedge clk) disable iff (rst)
        (sleep_o && bus_busy) |=> (wake_pulse_o && !sleep_o));

    // R5: the wake event lasts one cycle
    p_wake_single_r5: assert property (@(posedge clk) disable iff (rst)
        wake_pulse_o |=> !wake_pulse_o);

    // R6: pending is gone when the wake event fires
    p_pend_clear_r6: assert property (@(posedge clk) disable iff (rst)
        wake_pulse_o |-> !wake_pend_o);
endmodule

// File: rtl/loop_tracker.sv
module loop_tracker
    import can_shadow_pkg::*;
#(
    parameter int SETTLE_TICKS = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic ctrl_write,
    input  logic loop_req,
    input  logic core_en,
    input  logic can_tick,
    output logic loop_o
);
    localparam int DW = $clog2(SETTLE_TICKS + 1);
    localparam logic [DW-1:0] LAST = DW'(SETTLE_TICKS - 1);

    loop_state_t   state, state_nx;
    logic [DW-1:0] dly;
    logic          disable_wr;

    assign disable_wr = ctrl_write && !core_en;

    always_comb begin
        state_nx = state;
        unique case (state)
            L_CONFIG: begin
                if (ctrl_write && core_en) state_nx = loop_req ? L_SETTLE : L_NORMAL;
            end
            L_NORMAL: if (disable_wr) state_nx = L_CONFIG;
            L_SETTLE: begin
                if (disable_wr)                   state_nx = L_CONFIG;
                else if (can_tick && dly == LAST) state_nx = L_LOOP;
            end
            L_LOOP:   if (disable_wr) state_nx = L_CONFIG;
            default:  state_nx = L_CONFIG;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= L_CONFIG;
        else     state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dly    <= '0;
            loop_o <= 1'b0;
        end else begin
            loop_o <= (state_nx == L_LOOP);
            if (state != L_SETTLE || state_nx != L_SETTLE) dly <= '0;
            else if (can_tick)                              dly <= dly + DW'(1);
        end
    end

    // R7: loopback appears only right after a tick
    p_loop_after_tick_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(loop_o) |-> $past(can_tick));

    // R8: in normal operation a request never starts the settle delay
    p_normal_ignores_r8: assert property (@(posedge clk) disable iff (rst)
        (state == L_NORMAL && !disable_wr) |=> (state == L_NORMAL && !loop_o));

    // R9: clearing the enable drops loopback
    p_disable_drops_r9: assert property (@(posedge clk) disable iff (rst)
        disable_wr |=> (!loop_o && dly == '0));

    // R7: the delay counter stays inside its window
    p_dly_bound_r7: assert property (@(posedge clk) disable iff (rst)
        dly <= LAST);
endmodule

// File: rtl/can_mode_shadow.sv
module can_mode_shadow #(
    parameter int NUM_BUF      = 4,
    parameter int SETTLE_TICKS = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic tx_write,
    input  logic tx_done,
    input  logic bus_idle,
    input  logic bus_busy,
    input  logic ctrl_write,
    input  logic loop_req,
    input  logic core_en,
    input  logic can_tick,
    output logic sleep_o,
    output logic wake_pulse_o,
    output logic wake_pend_o,
    output logic loop_o
);
    logic buf_empty;

    tx_occupancy #(.NUM_BUF(NUM_BUF)) u_occ (
        .clk      (clk),
        .rst      (rst),
        .tx_write (tx_write),
        .tx_done  (tx_done),
        .empty    (buf_empty)
    );

    sleep_tracker u_sleep (
        .clk          (clk),
        .rst          (rst),
        .tx_write     (tx_write),
        .buf_empty    (buf_empty),
        .bus_idle     (bus_idle),
        .bus_busy     (bus_busy),
        .sleep_o      (sleep_o),
        .wake_pulse_o (wake_pulse_o),
        .wake_pend_o  (wake_pend_o)
    );

    loop_tracker #(.SETTLE_TICKS(SETTLE_TICKS)) u_loop (
        .clk        (clk),
        .rst        (rst),
        .ctrl_write (ctrl_write),
        .loop_req   (loop_req),
        .core_en    (core_en),
        .can_tick   (can_tick),
        .loop_o     (loop_o)
    );

    // R10: nothing is asserted in the first cycle after reset
    p_reset_quiet_r10: assert property (@(posedge clk)
        $fell(rst) |-> !(sleep_o || wake_pulse_o || wake_pend_o || loop_o));
endmodule

// File: tb/can_mode_shadow_test.sv
module can_mode_shadow_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tx_write = 0, tx_done = 0, bus_idle = 0, bus_busy = 0;
    logic ctrl_write = 0, loop_req = 0, core_en = 0, can_tick = 0;
    logic sleep_o, wake_pulse_o, wake_pend_o, loop_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    can_mode_shadow uut (
        .clk(clk), .rst(rst), .tx_write(tx_write), .tx_done(tx_done),
        .bus_idle(bus_idle), .bus_busy(bus_busy), .ctrl_write(ctrl_write),
        .loop_req(loop_req), .core_en(core_en), .can_tick(can_tick),
        .sleep_o(sleep_o), .wake_pulse_o(wake_pulse_o),
        .wake_pend_o(wake_pend_o), .loop_o(loop_o)
    );

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // drive one cycle of sleep-side inputs, then sample after the edge
    task automatic step(logic w, logic d, logic idle, logic busy);
        tx_write = w; tx_done = d; bus_idle = idle; bus_busy = busy;
        @(negedge clk);
        tx_write = 0; tx_done = 0; bus_idle = 0; bus_busy = 0;
    endtask

    task automatic ctrl(logic req, logic en);
        ctrl_write = 1; loop_req = req; core_en = en;
        @(negedge clk);
        ctrl_write = 0; loop_req = 0; core_en = 0;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            can_tick = 1; @(negedge clk);
            can_tick = 0; @(negedge clk);
        end
    endtask

    task automatic wake_up();
        step(0, 0, 0, 1);
    endtask

    task automatic t_reset();
        chk("R10 sleep", sleep_o, 0);
        chk("R10 wake", wake_pulse_o, 0);
        chk("R10 pend", wake_pend_o, 0);
        chk("R10 loop", loop_o, 0);
    endtask

    task automatic t_entry_and_wake();
        step(0, 0, 1, 0);
        chk("R2 entry", sleep_o, 1);
        chk("R5 no pulse yet", wake_pulse_o, 0);
        step(0, 0, 1, 0);
        chk("R2 stays asleep", sleep_o, 1);
        wake_up();
        chk("R5 sleep cleared", sleep_o, 0);
        chk("R5 wake pulse", wake_pulse_o, 1);
        step(0, 0, 0, 0);
        chk("R5 pulse one cycle", wake_pulse_o, 0);
    endtask

    task automatic t_blocked_entry();
        step(1, 0, 0, 0);
        step(0, 0, 1, 0);
        step(0, 0, 1, 0);
        chk("R3 outstanding blocks", sleep_o, 0);
        step(0, 1, 0, 0);
        step(0, 0, 0, 1);
        chk("R3 busy alone no entry", sleep_o, 0);
        step(1, 0, 1, 0);
        chk("R3 same-cycle write blocks", sleep_o, 0);
        step(0, 1, 0, 0);
        step(0, 0, 1, 0);
        chk("R3 entry after drain", sleep_o, 1);
        wake_up();
    endtask

    task automatic t_saturate_top();
        for (int i = 0; i < 5; i++) step(1, 0, 0, 0);
        for (int i = 0; i < 3; i++) step(0, 1, 0, 0);
        step(0, 0, 1, 0);
        chk("R1 one left after 3 done", sleep_o, 0);
        step(0, 1, 0, 0);
        step(0, 0, 1, 0);
        chk("R1 saturates at NUM_BUF", sleep_o, 1);
        wake_up();
    endtask

    task automatic t_saturate_zero();
        step(0, 1, 0, 0);
        step(0, 1, 0, 0);
        step(1, 0, 0, 0);
        step(0, 0, 1, 0);
        chk("R1 floor at zero", sleep_o, 0);
        step(0, 1, 0, 0);
        step(0, 0, 1, 0);
        chk("R1 drained after floor", sleep_o, 1);
        wake_up();
    endtask

    task automatic t_simultaneous();
        step(1, 0, 0, 0);
        step(1, 1, 0, 0);
        step(0, 0, 1, 0);
        chk("R1 write+done holds", sleep_o, 0);
        step(0, 1, 0, 0);
        step(0, 0, 1, 0);
        chk("R1 hold then drain", sleep_o, 1);
        wake_up();
    endtask

    task automatic t_pending();
        step(0, 0, 1, 0);
        chk("R4 asleep before write", sleep_o, 1);
        step(1, 0, 0, 0);
        chk("R4 pend set", wake_pend_o, 1);
        chk("R4 still asleep", sleep_o, 1);
        wake_up();
        chk("R6 pend cleared with pulse", wake_pend_o, 0);
        chk("R6 pulse fired", wake_pulse_o, 1);
        step(0, 1, 0, 0);
    endtask

    task automatic t_loop_delay();
        ctrl(1, 1);
        ticks(5);
        chk("R7 not before sixth tick", loop_o, 0);
        can_tick = 1; @(negedge clk); can_tick = 0;
        chk("R7 after sixth tick", loop_o, 1);
        ticks(2);
        chk("R7 stays in loopback", loop_o, 1);
        ctrl(0, 0);
        chk("R9 disable drops loop", loop_o, 0);
    endtask

    task automatic t_loop_restart();
        ctrl(1, 1);
        ticks(3);
        ctrl(0, 0);
        ctrl(1, 1);
        ticks(5);
        chk("R9 delay restarted", loop_o, 0);
        ticks(1);
        chk("R9 full delay after restart", loop_o, 1);
        ctrl(0, 0);
    endtask

    task automatic t_loop_ignored();
        ctrl(0, 1);
        ctrl(1, 1);
        ticks(8);
        chk("R8 request ignored when enabled", loop_o, 0);
        ctrl(0, 0);
        ctrl(1, 1);
        ticks(6);
        chk("R8 request works from config", loop_o, 1);
        ctrl(0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 0;
        @(negedge clk);
        t_reset();
        t_entry_and_wake();
        t_blocked_entry();
        t_saturate_top();
        t_saturate_zero();
        t_simultaneous();
        t_pending();
        t_loop_delay();
        t_loop_restart();
        t_loop_ignored();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule